// File: doc/BRIEF.md
# Streaming Trilinear Resampler

This unit turns a raster stream of 8-bit volume samples into a stream of trilinearly resampled values, one per clock. Voxels arrive one per accepted cycle: X fastest, then Y, then slice by slice in Z, each slice holding N×N voxels. Every voxel is seen exactly once. An internal plane store replays the previous slice, and two short delay chains supply the neighbours one position back and one beam back. Together they give the eight corners of the cell whose far corner is the voxel that has just arrived.

A template generator upstream presents three 8-bit fractional weights with each voxel. A tree of seven two-input blends (four along X, two along Y, one along Z) combines the corners in a fully pipelined datapath. A control tag word entered with each voxel leaves with the sample built on that voxel. Gaps in the input stream do not disturb the spatial alignment, because positions advance only on accepted voxels.

Top module: `trilin_unit`

## Requirements
- R1: While reset is held and in the cycles just after it, `outValid` is low.
- R2: Each blend computes lerp(a,b,w) = a + floor(((b−a)·w + 128) / 256). Corner bit order is {z,y,x}, and a bit set to 1 selects the far position (the current voxel's coordinate rather than the one below it). The four X blends pair corners 2i and 2i+1 with `inWx`. The two Y blends pair the X results 2j and 2j+1 with `inWy`. The Z blend pairs the two Y results with `inWz`.
- R3: A sample appears exactly 4 clock cycles after the voxel at its far corner is accepted.
- R4: A voxel yields a sample only when its position has x≥1, y≥1 and z≥1. The first slice, the first beam of each slice and the first voxel of each beam produce nothing.
- R5: `inStart` marks the voxel at position (0,0,0) of a new volume and restarts position counting there, even in the middle of a volume. Positions advance only on cycles with `inValid` high.
- R6: `outTag` equals the `inTag` presented with the far-corner voxel.
- R7: Back-to-back accepted voxels produce back-to-back samples, one per cycle.
- R8: All weights zero give the near corner (x−1,y−1,z−1) unchanged. All weights 255 follow the same rounding formula.
- R9: Voxel, weight and tag values on cycles with `inValid` low have no effect on any sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Voxel accepted this cycle |
| inStart | input | 1 | Voxel is position (0,0,0) of a volume |
| inVoxel | input | 8 | Voxel value |
| inWx | input | 8 | X fraction for the sample at this voxel |
| inWy | input | 8 | Y fraction |
| inWz | input | 8 | Z fraction |
| inTag | input | TAG_W | Control tag carried with the sample |
| outValid | output | 1 | Sample valid |
| outSample | output | 8 | Resampled value |
| outTag | output | TAG_W | Tag of the far-corner voxel |

## Verification
The assertions assume that the source keeps to raster order with exactly N×N voxels per slice, and that `inStart` is raised only on the first voxel of a volume. The latency and tag properties count on the pipeline advancing every cycle and never stalling. The stimulus builds its volumes in strict raster order with a small N. It raises `inStart` only at volume starts, including one restart partway through a slice. Gap cycles carry random junk on every data input, so that any leak of idle-cycle data shows up in the values.

// File: rtl/trilin_pkg.sv
package trilin_pkg;
  localparam int VOX_W  = 8;
  localparam int FRAC_W = 8;

  typedef struct packed {
    logic push;   // voxel accepted: advance stores
    logic emit;   // accepted voxel closes a complete cell
  } tlStrobe_t;

  // a + floor(((b - a) * w + half) / 2^FRAC_W)
  function automatic logic [VOX_W-1:0] lerpVox(input logic [VOX_W-1:0] a,
                                                input logic [VOX_W-1:0] b,
                                                input logic [FRAC_W-1:0] w);
    logic signed [VOX_W+1:0]        diff;
    logic signed [VOX_W+FRAC_W+2:0] prod;
    logic signed [VOX_W+FRAC_W+2:0] step;
    diff = $signed({2'b00, b}) - $signed({2'b00, a});
    prod = diff * $signed({1'b0, w});
    prod = prod + $signed((VOX_W+FRAC_W+3)'(1) <<< (FRAC_W - 1));
    step = prod >>> FRAC_W;
    return VOX_W'(a + step[VOX_W-1:0]);
  endfunction
endpackage

// File: rtl/trilin_ctrl.sv
module trilin_ctrl
  import trilin_pkg::*;
#(
  parameter int N = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inStart,
  output tlStrobe_t strobe
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] xCnt, yCnt;
  logic          deepCnt;
  logic [CW-1:0] curX, curY;
  logic          curDeep, lastX, lastY;

  always_comb begin
    curX    = inStart ? '0 : xCnt;
    curY    = inStart ? '0 : yCnt;
    curDeep = inStart ? 1'b0 : deepCnt;
    lastX   = (curX == LAST);
    lastY   = (curY == LAST);
    strobe.push = inValid;
    strobe.emit = inValid && (curX != '0) && (curY != '0) && curDeep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xCnt    <= '0;
      yCnt    <= '0;
      deepCnt <= 1'b0;
    end else if (inValid) begin
      xCnt <= lastX ? '0 : curX + 1'b1;
      if (lastX) yCnt <= lastY ? '0 : curY + 1'b1;
      else       yCnt <= curY;
      deepCnt <= (lastX && lastY) ? 1'b1 : curDeep;
    end
  end

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(xCnt) && $stable(yCnt) && $stable(deepCnt)); // R5
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    xCnt <= LAST && yCnt <= LAST); // R5
endmodule

// File: rtl/trilin_datapath.sv
module trilin_datapath
  import trilin_pkg::*;
#(
  parameter int N     = 8,
  parameter int TAG_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  tlStrobe_t         strobe,
  input  logic [VOX_W-1:0]  inVoxel,
  input  logic [FRAC_W-1:0] inWx,
  input  logic [FRAC_W-1:0] inWy,
  input  logic [FRAC_W-1:0] inWz,
  input  logic [TAG_W-1:0]  inTag,
  output logic              outValid,
  output logic [VOX_W-1:0]  outSample,
  output logic [TAG_W-1:0]  outTag
);
  localparam int PLANE = N * N;
  localparam int PW    = (PLANE > 2) ? $clog2(PLANE) : 1;
  localparam int CHAIN = N + 1;
  localparam int NX    = 4;
  localparam int NY    = 2;

  // plane store: replays the voxel exactly one slice back
  logic [VOX_W-1:0] planeMem [PLANE];
  logic [PW-1:0]    planePtr;
  logic [VOX_W-1:0] planeOut;

  assign planeOut = planeMem[planePtr];

  always_ff @(posedge clk) begin
    if (strobe.push) planeMem[planePtr] <= inVoxel;
  end

  always_ff @(posedge clk) begin
    if (rst) planePtr <= '0;
    else if (strobe.push)
      planePtr <= (planePtr == PW'(PLANE - 1)) ? '0 : planePtr + 1'b1;
  end

  // neighbour chains for the current and the replayed slice
  logic [VOX_W-1:0] curChain  [CHAIN];
  logic [VOX_W-1:0] prevChain [CHAIN];

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      curChain[0]  <= inVoxel;
      prevChain[0] <= planeOut;
    end
  end

  genvar k;
  generate
    for (k = 1; k < CHAIN; k++) begin : g_chain
      always_ff @(posedge clk) begin
        if (strobe.push) begin
          curChain[k]  <= curChain[k-1];
          prevChain[k] <= prevChain[k-1];
        end
      end
    end
  endgenerate

  // corner index {z,y,x}; 1 = far position
  logic [VOX_W-1:0] cornerIn [8];
  always_comb begin
    cornerIn[7] = inVoxel;
    cornerIn[6] = curChain[0];
    cornerIn[5] = curChain[N-1];
    cornerIn[4] = curChain[N];
    cornerIn[3] = planeOut;
    cornerIn[2] = prevChain[0];
    cornerIn[1] = prevChain[N-1];
    cornerIn[0] = prevChain[N];
  end

  // stage 0: corners and weights
  logic              s0Valid;
  logic [VOX_W-1:0]  s0Corner [8];
  logic [FRAC_W-1:0] s0Wx, s0Wy, s0Wz;
  logic [TAG_W-1:0]  s0Tag;

  always_ff @(posedge clk) begin
    if (rst) s0Valid <= 1'b0;
    else     s0Valid <= strobe.emit;
    s0Corner <= cornerIn;
    s0Wx     <= inWx;
    s0Wy     <= inWy;
    s0Wz     <= inWz;
    s0Tag    <= inTag;
  end

  // stage 1: four X blends
  logic              s1Valid;
  logic [VOX_W-1:0]  s1X [NX];
  logic [FRAC_W-1:0] s1Wy, s1Wz;
  logic [TAG_W-1:0]  s1Tag;

  genvar i;
  generate
    for (i = 0; i < NX; i++) begin : g_xblend
      always_ff @(posedge clk) begin
        s1X[i] <= lerpVox(s0Corner[2*i], s0Corner[2*i+1], s0Wx);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) s1Valid <= 1'b0;
    else     s1Valid <= s0Valid;
    s1Wy  <= s0Wy;
    s1Wz  <= s0Wz;
    s1Tag <= s0Tag;
  end

  // stage 2: two Y blends
  logic              s2Valid;
  logic [VOX_W-1:0]  s2Y [NY];
  logic [FRAC_W-1:0] s2Wz;
  logic [TAG_W-1:0]  s2Tag;

  genvar j;
  generate
    for (j = 0; j < NY; j++) begin : g_yblend
      always_ff @(posedge clk) begin
        s2Y[j] <= lerpVox(s1X[2*j], s1X[2*j+1], s1Wy);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) s2Valid <= 1'b0;
    else     s2Valid <= s1Valid;
    s2Wz  <= s1Wz;
    s2Tag <= s1Tag;
  end

  // stage 3: Z blend
  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= s2Valid;
    outSample <= lerpVox(s2Y[0], s2Y[1], s2Wz);
    outTag    <= s2Tag;
  end

  AST_XBLEND_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    s1Valid |-> ((s1X[0] >= $past(s0Corner[0]) && s1X[0] <= $past(s0Corner[1])) ||
                 (s1X[0] <= $past(s0Corner[0]) && s1X[0] >= $past(s0Corner[1])))); // R2
  AST_ZBLEND_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ((outSample >= $past(s2Y[0]) && outSample <= $past(s2Y[1])) ||
                  (outSample <= $past(s2Y[0]) && outSample >= $past(s2Y[1])))); // R2
endmodule

// File: rtl/trilin_unit.sv
module trilin_unit
  import trilin_pkg::*;
#(
  parameter int N     = 8,
  parameter int TAG_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inStart,
  input  logic [VOX_W-1:0]  inVoxel,
  input  logic [FRAC_W-1:0] inWx,
  input  logic [FRAC_W-1:0] inWy,
  input  logic [FRAC_W-1:0] inWz,
  input  logic [TAG_W-1:0]  inTag,
  output logic              outValid,
  output logic [VOX_W-1:0]  outSample,
  output logic [TAG_W-1:0]  outTag
);
  tlStrobe_t strobe;

  trilin_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inStart (inStart),
    .strobe  (strobe)
  );

  trilin_datapath #(.N(N), .TAG_W(TAG_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .inVoxel   (inVoxel),
    .inWx      (inWx),
    .inWy      (inWy),
    .inWz      (inWz),
    .inTag     (inTag),
    .outValid  (outValid),
    .outSample (outSample),
    .outTag    (outTag)
  );

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 4)); // R3
  AST_TAG_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outTag == $past(inTag, 4)); // R6
  AST_START_SILENT: assert property (@(posedge clk) disable iff (rst)
    inValid && inStart |-> ##4 !outValid); // R4
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> ##4 !outValid); // R9
endmodule

// File: tb/tb_trilin_unit.sv
module tb_trilin_unit;
  localparam int TB_N  = 4;
  localparam int TAG_W = 13;
  localparam int ZMAX  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inStart = 1'b0;
  logic [7:0] inVoxel = '0, inWx = '0, inWy = '0, inWz = '0;
  logic [TAG_W-1:0] inTag = '0;
  logic outValid;
  logic [7:0] outSample;
  logic [TAG_W-1:0] outTag;

  always #2.5 clk = ~clk;

  trilin_unit #(.N(TB_N), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inStart(inStart),
    .inVoxel(inVoxel), .inWx(inWx), .inWy(inWy), .inWz(inWz), .inTag(inTag),
    .outValid(outValid), .outSample(outSample), .outTag(outTag)
  );

  typedef struct {
    int    val;
    int    tag;
    int    cyc;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, failures = 0, cyc = 0, outSeen = 0, expTotal = 0;
  int vol [ZMAX][TB_N][TB_N];
  int mx = 0, my = 0, mz = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lerpRef(int a, int b, int w);
    return a + (((b - a) * w + 128) >>> 8);
  endfunction

  task automatic fail(string req, string what, int act, int exp);
    failures++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic sendVox(int vx, int wx, int wy, int wz, bit st, int tg, string req);
    int c [8];
    int xr [4];
    int yr [2];
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1; inStart = st; inVoxel = 8'(vx);
    inWx = 8'(wx); inWy = 8'(wy); inWz = 8'(wz); inTag = TAG_W'(tg);
    if (st) begin mx = 0; my = 0; mz = 0; end
    vol[mz][my][mx] = vx;
    if (mx > 0 && my > 0 && mz > 0) begin
      for (int k = 0; k < 8; k++)
        c[k] = vol[mz - 1 + ((k >> 2) & 1)][my - 1 + ((k >> 1) & 1)][mx - 1 + (k & 1)];
      for (int i = 0; i < 4; i++) xr[i] = lerpRef(c[2*i], c[2*i+1], wx);
      for (int j = 0; j < 2; j++) yr[j] = lerpRef(xr[2*j], xr[2*j+1], wy);
      it.val = lerpRef(yr[0], yr[1], wz);
      if (wx == 0 && wy == 0 && wz == 0 && it.val != c[0]) begin
        checks++;
        fail("R8", "zero-weight model", it.val, c[0]);
      end
      it.tag = tg; it.cyc = cyc + 4; it.req = req;
      expQ.push_back(it);
      expTotal++;
    end
    mx++;
    if (mx == TB_N) begin mx = 0; my++; end
    if (my == TB_N) begin my = 0; mz++; end
  endtask

  task automatic idleCycle();
    @(negedge clk);
    inValid = 1'b0; inStart = $urandom_range(0, 1);
    inVoxel = 8'($urandom); inWx = 8'($urandom); inWy = 8'($urandom);
    inWz = 8'($urandom); inTag = TAG_W'($urandom);
  endtask

  // mode 0: random weights, 1: zero weights, 2: full weights
  task automatic sendVolume(int slices, int gapEvery, int mode, string req);
    for (int n = 0; n < slices * TB_N * TB_N; n++) begin
      int w0, w1, w2;
      w0 = (mode == 0) ? $urandom_range(0, 255) : (mode == 1 ? 0 : 255);
      w1 = (mode == 0) ? $urandom_range(0, 255) : (mode == 1 ? 0 : 255);
      w2 = (mode == 0) ? $urandom_range(0, 255) : (mode == 1 ? 0 : 255);
      sendVox($urandom_range(0, 255), w0, w1, w2, n == 0, $urandom_range(0, 8191), req);
      if (gapEvery > 0 && (n % gapEvery) == gapEvery - 1) begin
        idleCycle();
        idleCycle();
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !finished && outValid) begin
      expItem_t it;
      outSeen++;
      if (expQ.size() == 0) begin
        checks++;
        fail("R4", "unexpected sample", int'(outSample), -1);
      end else begin
        it = expQ.pop_front();
        checks++;
        if (int'(outSample) != it.val) fail(it.req, "sample", int'(outSample), it.val);
        checks++;
        if (int'(outTag) != it.tag) fail("R6", "tag", int'(outTag), it.tag);
        checks++;
        if (cyc != it.cyc) fail("R3", "arrival cycle", cyc, it.cyc);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 40000 && !finished) begin
      finished = 1;
      checks++;
      fail("ALL", "watchdog expired", cyc, 40000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (outValid !== 1'b0) fail("R1", "outValid in reset", int'(outValid), 0);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0) fail("R1", "outValid after reset", int'(outValid), 0);
    end
    // R2 R7: dense stream, random weights
    sendVolume(3, 0, 0, "R2");
    idleCycle();
    // R9 R5: gaps with junk inputs
    sendVolume(3, 3, 0, "R9");
    idleCycle();
    // R8: weight extremes
    sendVolume(2, 0, 1, "R8");
    sendVolume(2, 0, 2, "R8");
    // R5: restart partway through the second slice
    for (int n = 0; n < TB_N * TB_N + 6; n++)
      sendVox($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
              $urandom_range(0, 255), n == 0, n, "R5");
    sendVolume(2, 0, 0, "R5");
    repeat (10) idleCycle();
    checks++;
    if (expQ.size() != 0) fail("R4", "missing samples", 0, expQ.size());
    checks++;
    if (outSeen != expTotal) fail("R4", "sample count", outSeen, expTotal);
    checks++;
    if (outValid !== 1'b0) fail("R9", "outValid while idle", int'(outValid), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule